// File: doc/BRIEF.md
# Loss-of-Signal Output Gate with Edge Masking

This block sits between the amplitude comparator of a receiver front end and the loss-of-signal pin. It takes the comparator's raw flag (high when the incoming amplitude is below the programmed threshold) and registers it onto the output. After each change of the output it can open a hold-off window that freezes the output, so that a burst of chatter right after the signal drops out or returns does not reach the host. Upward and downward output changes each have their own enable bit and their own 7-bit window length. One unit of window length is 32 microsecond ticks, so the longest window is about 4 ms and a unit is 32 µs.

The same block also produces the 7-bit threshold code that goes to the analog level circuit and to a read-only status field. When software has not chosen its own level, a built-in default code is used. That default depends on which of the two threshold ranges is active. When software has chosen a level, its 7-bit code is passed through. The code is registered.

The clock is the control clock. A one-cycle `us_tick_i` pulse each microsecond is the only timebase the windows count.

Top module: `sigloss_gate`

## Requirements
- R1: While `rst_n` is low and on its release, `los_o` is 1, no hold-off window is open, and `sel_code_o` equals the low-range default code (64).
- R2: With no window open, `los_o` on each clock edge takes the value `raw_los_i` had at that edge, so the output follows the input one cycle later.
- R3: When `los_o` goes from 0 to 1 while `rise_mask_en_i` is 1 and `rise_mask_dur_i` = D is nonzero, `los_o` stays 1 whatever `raw_los_i` does until D×32 tick pulses have been counted. On the clock after the edge that takes the last of those ticks, `los_o` takes `raw_los_i` again.
- R4: When `los_o` goes from 1 to 0 while `fall_mask_en_i` is 1 and `fall_mask_dur_i` = D is nonzero, `los_o` stays 0 for D×32 tick pulses, with the same release timing as R3.
- R5: If the enable bit for an edge direction is 0, or its duration is 0, no window opens on that edge and `los_o` keeps following `raw_los_i` with one cycle of latency.
- R6: A window advances only on clock edges where `us_tick_i` is 1. Any number of clocks without a tick leaves it open and the output held.
- R7: When `lvl_sel_i` is 1, `sel_code_o` equals the `lvl_code_i` value from the previous clock edge, whatever `range_hi_i` is.
- R8: When `lvl_sel_i` is 0, `sel_code_o` becomes the default code on the next clock edge. The default is 64 when `range_hi_i` is 0 and 0 when `range_hi_i` is 1, because the 25 mVp-p default lies below the high range and clamps to its lowest code.
- R9: A window's duration is captured on the edge that opens it. Changing the enable or duration inputs while the window is open does not shorten or lengthen that window.
- R10: When a window closes, the output takes the raw value. If that value differs from the held value, the output changes and the window for the opposite direction opens, provided that direction is enabled with a nonzero duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| raw_los_i | input | 1 | Comparator flag, 1 = amplitude below threshold |
| range_hi_i | input | 1 | Threshold range select, 1 = high range |
| lvl_sel_i | input | 1 | 1 = use `lvl_code_i`, 0 = use the default code |
| lvl_code_i | input | 7 | Software threshold code |
| fall_mask_en_i | input | 1 | Enable hold-off after a 1→0 output change |
| fall_mask_dur_i | input | 7 | Hold-off length after a 1→0 change, in units of 32 ticks |
| rise_mask_en_i | input | 1 | Enable hold-off after a 0→1 output change |
| rise_mask_dur_i | input | 7 | Hold-off length after a 0→1 change, in units of 32 ticks |
| us_tick_i | input | 1 | One-cycle timebase pulse, nominally 1 µs |
| los_o | output | 1 | Masked loss-of-signal output |
| sel_code_o | output | 7 | Registered threshold code for the analog circuit and the status field |

## Verification
The assertions assume that `raw_los_i` and `us_tick_i` are already synchronous to `clk`, that a tick is a single-cycle pulse, and that `rst_n` is released away from a clock edge. The bench drives every input one time unit after a rising edge and keeps ticks one cycle wide with at least one idle cycle between them. It also toggles the raw flag inside open windows, so the holding behaviour is tested against a changing input rather than a static one.

// File: rtl/sigloss_pkg.sv
package sigloss_pkg;
  // Which hold-off window, if any, currently freezes the output
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_RISE = 2'd1,
    WIN_FALL = 2'd2
  } win_e;
endpackage

// File: rtl/sigloss_level_sel.sv
module sigloss_level_sel #(
  parameter int unsigned CODE_W      = 7,
  parameter int unsigned DEF_CODE_LO = 64,
  parameter int unsigned DEF_CODE_HI = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_sel_i,
  input  logic              range_hi_i,
  input  logic [CODE_W-1:0] lvl_code_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] DEF_LO_C = DEF_CODE_LO[CODE_W-1:0];
  localparam logic [CODE_W-1:0] DEF_HI_C = DEF_CODE_HI[CODE_W-1:0];

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    if (lvl_sel_i) code_d = lvl_code_i;
    else           code_d = range_hi_i ? DEF_HI_C : DEF_LO_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= DEF_LO_C;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  p_user_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_sel_i |=> code_o == $past(lvl_code_i));
  p_default_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_sel_i && !range_hi_i) |=> code_o == DEF_LO_C);
  p_default_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_sel_i && range_hi_i) |=> code_o == DEF_HI_C);
endmodule

// File: rtl/sigloss_mask_timer.sv
module sigloss_mask_timer #(
  parameter int unsigned DUR_W   = 7,
  parameter int unsigned PRESC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [PRESC_W-1:0] PRE_LAST = {PRESC_W{1'b1}};
  localparam logic [DUR_W-1:0]   CNT_ONE  = {{(DUR_W-1){1'b0}}, 1'b1};

  logic [DUR_W-1:0]   cnt_q, cnt_d;
  logic [PRESC_W-1:0] pre_q, pre_d;
  logic               busy, wrap, step_en;

  assign busy    = (cnt_q != '0);
  assign wrap    = busy && tick_i && (pre_q == PRE_LAST);
  assign step_en = load_i || (busy && tick_i);

  always_comb begin
    cnt_d = cnt_q;
    pre_d = pre_q;
    if (load_i) begin
      cnt_d = dur_i;
      pre_d = '0;
    end else if (busy && tick_i) begin
      pre_d = pre_q + 1'b1;
      if (wrap) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (step_en) begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

  assign busy_o = busy;
  assign done_o = wrap && (cnt_q == CNT_ONE);

  p_frozen_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i && !load_i) |=> ($stable(cnt_q) && $stable(pre_q)));
  p_done_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> !busy_o);
  p_load_captures_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(dur_i)) && (pre_q == '0));
endmodule

// File: rtl/sigloss_gate.sv
module sigloss_gate
  import sigloss_pkg::*;
#(
  parameter int unsigned CODE_W      = 7,
  parameter int unsigned DUR_W       = 7,
  parameter int unsigned PRESC_W     = 5,
  parameter int unsigned DEF_CODE_LO = 64,
  parameter int unsigned DEF_CODE_HI = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_los_i,
  input  logic              range_hi_i,
  input  logic              lvl_sel_i,
  input  logic [CODE_W-1:0] lvl_code_i,
  input  logic              fall_mask_en_i,
  input  logic [DUR_W-1:0]  fall_mask_dur_i,
  input  logic              rise_mask_en_i,
  input  logic [DUR_W-1:0]  rise_mask_dur_i,
  input  logic              us_tick_i,
  output logic              los_o,
  output logic [CODE_W-1:0] sel_code_o
);
  logic             los_q, los_d;
  win_e             win_q, win_d;
  logic             load;
  logic [DUR_W-1:0] load_dur;
  logic             tmr_busy, tmr_done;
  logic             rise_arm, fall_arm;

  assign rise_arm = rise_mask_en_i && (rise_mask_dur_i != '0);
  assign fall_arm = fall_mask_en_i && (fall_mask_dur_i != '0);

  // Next-state: follow raw when idle, open a window on an output change
  always_comb begin
    los_d    = los_q;
    win_d    = win_q;
    load     = 1'b0;
    load_dur = rise_mask_dur_i;
    unique case (win_q)
      WIN_NONE: begin
        los_d = raw_los_i;
        if (raw_los_i && !los_q && rise_arm) begin
          load     = 1'b1;
          load_dur = rise_mask_dur_i;
          win_d    = WIN_RISE;
        end else if (!raw_los_i && los_q && fall_arm) begin
          load     = 1'b1;
          load_dur = fall_mask_dur_i;
          win_d    = WIN_FALL;
        end
      end
      default: begin
        if (tmr_done) win_d = WIN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q <= 1'b1;
      win_q <= WIN_NONE;
    end else begin
      los_q <= los_d;
      win_q <= win_d;
    end
  end

  sigloss_mask_timer #(
    .DUR_W   (DUR_W),
    .PRESC_W (PRESC_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .dur_i  (load_dur),
    .tick_i (us_tick_i),
    .busy_o (tmr_busy),
    .done_o (tmr_done)
  );

  sigloss_level_sel #(
    .CODE_W      (CODE_W),
    .DEF_CODE_LO (DEF_CODE_LO),
    .DEF_CODE_HI (DEF_CODE_HI)
  ) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_sel_i  (lvl_sel_i),
    .range_hi_i (range_hi_i),
    .lvl_code_i (lvl_code_i),
    .code_o     (sel_code_o)
  );

  assign los_o = los_q;

  p_follow_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_NONE) |=> los_o == $past(raw_los_i));
  p_hold_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != WIN_NONE) |=> $stable(los_o));
  p_rise_window_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_RISE) |-> los_o);
  p_fall_window_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_FALL) |-> !los_o);
  p_timer_agrees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != WIN_NONE) == tmr_busy);
  p_unarmed_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_NONE && raw_los_i && !los_o && !rise_arm) |=> win_q == WIN_NONE);
  p_unarmed_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_NONE && !raw_los_i && los_o && !fall_arm) |=> win_q == WIN_NONE);
endmodule

// File: tb/sim_sigloss_gate.sv
module sim_sigloss_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       raw_los_i, range_hi_i, lvl_sel_i;
  logic [6:0] lvl_code_i;
  logic       fall_mask_en_i, rise_mask_en_i;
  logic [6:0] fall_mask_dur_i, rise_mask_dur_i;
  logic       us_tick_i;
  logic       los_o;
  logic [6:0] sel_code_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sigloss_gate u0 (
    .clk(clk), .rst_n(rst_n), .raw_los_i(raw_los_i), .range_hi_i(range_hi_i),
    .lvl_sel_i(lvl_sel_i), .lvl_code_i(lvl_code_i),
    .fall_mask_en_i(fall_mask_en_i), .fall_mask_dur_i(fall_mask_dur_i),
    .rise_mask_en_i(rise_mask_en_i), .rise_mask_dur_i(rise_mask_dur_i),
    .us_tick_i(us_tick_i), .los_o(los_o), .sel_code_o(sel_code_o)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick_i = 1'b1; cyc(1);
      us_tick_i = 1'b0; cyc(1);
    end
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; raw_los_i = 1'b0; range_hi_i = 1'b0; lvl_sel_i = 1'b0;
    lvl_code_i = '0; fall_mask_en_i = 1'b0; rise_mask_en_i = 1'b0;
    fall_mask_dur_i = '0; rise_mask_dur_i = '0; us_tick_i = 1'b0;
    cyc(3);
    chk({7'd0, los_o}, 8'd1, "R1 los during reset");
    rst_n = 1'b1;
    chk({7'd0, los_o}, 8'd1, "R1 los after release");
    chk({1'b0, sel_code_o}, 8'd64, "R1 code after release");
    cyc(1);
    chk({7'd0, los_o}, 8'd0, "R2 first follow after reset");
  endtask

  task automatic t_follow;
    logic [4:0] pat = 5'b01101;
    for (int i = 0; i < 5; i++) begin
      raw_los_i = pat[i]; cyc(1);
      chk({7'd0, los_o}, {7'd0, pat[i]}, "R2 follow pattern");
    end
    raw_los_i = 1'b0; cyc(1);
  endtask

  task automatic t_rise_mask;
    rise_mask_en_i = 1'b1; rise_mask_dur_i = 7'd2;
    raw_los_i = 1'b1; cyc(1);
    chk({7'd0, los_o}, 8'd1, "R3 output rises");
    raw_los_i = 1'b0;
    ticks(20);
    raw_los_i = 1'b1; ticks(3); raw_los_i = 1'b0;
    ticks(40);
    chk({7'd0, los_o}, 8'd1, "R3 held after 63 ticks");
    us_tick_i = 1'b1; cyc(1); us_tick_i = 1'b0;
    chk({7'd0, los_o}, 8'd1, "R3 held on final tick edge");
    cyc(1);
    chk({7'd0, los_o}, 8'd0, "R3 released to raw");
    rise_mask_en_i = 1'b0; cyc(1);
  endtask

  task automatic t_fall_mask;
    fall_mask_en_i = 1'b1; fall_mask_dur_i = 7'd1;
    raw_los_i = 1'b1; cyc(2);
    chk({7'd0, los_o}, 8'd1, "R5 rise unmasked when disabled");
    raw_los_i = 1'b0; cyc(1);
    chk({7'd0, los_o}, 8'd0, "R4 output falls");
    raw_los_i = 1'b1;
    ticks(31);
    chk({7'd0, los_o}, 8'd0, "R4 held after 31 ticks");
    us_tick_i = 1'b1; cyc(1); us_tick_i = 1'b0;
    chk({7'd0, los_o}, 8'd0, "R4 held on final tick edge");
    cyc(1);
    chk({7'd0, los_o}, 8'd1, "R4 released to raw");
    fall_mask_en_i = 1'b0; raw_los_i = 1'b0; cyc(2);
    chk({7'd0, los_o}, 8'd0, "R5 fall unmasked when disabled");
  endtask

  task automatic t_disabled;
    rise_mask_en_i = 1'b1; rise_mask_dur_i = 7'd0;
    fall_mask_en_i = 1'b0; fall_mask_dur_i = 7'd5;
    raw_los_i = 1'b1; cyc(1);
    chk({7'd0, los_o}, 8'd1, "R5 zero duration rise");
    raw_los_i = 1'b0; cyc(1);
    chk({7'd0, los_o}, 8'd0, "R5 no window after zero duration");
    rise_mask_en_i = 1'b0; rise_mask_dur_i = 7'd3;
    raw_los_i = 1'b1; cyc(1);
    raw_los_i = 1'b0; cyc(1);
    chk({7'd0, los_o}, 8'd0, "R5 enable cleared ignores duration");
    cyc(1);
  endtask

  task automatic t_no_tick;
    rise_mask_en_i = 1'b1; rise_mask_dur_i = 7'd1;
    raw_los_i = 1'b1; cyc(1);
    raw_los_i = 1'b0;
    ticks(31);
    cyc(300);
    chk({7'd0, los_o}, 8'd1, "R6 frozen without ticks");
    ticks(1);
    chk({7'd0, los_o}, 8'd0, "R6 last tick releases");
    rise_mask_en_i = 1'b0; cyc(1);
  endtask

  task automatic t_midchange;
    rise_mask_en_i = 1'b1; rise_mask_dur_i = 7'd1;
    raw_los_i = 1'b1; cyc(1);
    raw_los_i = 1'b0;
    rise_mask_en_i = 1'b0; rise_mask_dur_i = 7'd0;
    ticks(31);
    chk({7'd0, los_o}, 8'd1, "R9 window kept after inputs change");
    ticks(1);
    chk({7'd0, los_o}, 8'd0, "R9 window ends at captured length");
    cyc(1);
  endtask

  task automatic t_reopen;
    rise_mask_en_i = 1'b1; rise_mask_dur_i = 7'd1;
    fall_mask_en_i = 1'b1; fall_mask_dur_i = 7'd1;
    raw_los_i = 1'b1; cyc(1);
    ticks(32);
    chk({7'd0, los_o}, 8'd1, "R10 same value after close");
    raw_los_i = 1'b0; cyc(1);
    chk({7'd0, los_o}, 8'd0, "R10 no new window when value matched");
    raw_los_i = 1'b1;
    ticks(31);
    chk({7'd0, los_o}, 8'd0, "R10 fall window holds");
    us_tick_i = 1'b1; cyc(1); us_tick_i = 1'b0;
    cyc(1);
    chk({7'd0, los_o}, 8'd1, "R10 changes after close");
    raw_los_i = 1'b0; cyc(3);
    chk({7'd0, los_o}, 8'd1, "R10 opposite window opened");
    fall_mask_en_i = 1'b0;
    ticks(32);
    chk({7'd0, los_o}, 8'd0, "R10 opposite window closes");
    rise_mask_en_i = 1'b0; cyc(1);
  endtask

  task automatic t_level;
    lvl_sel_i = 1'b0; range_hi_i = 1'b0; cyc(1);
    chk({1'b0, sel_code_o}, 8'd64, "R8 low range default");
    range_hi_i = 1'b1; cyc(1);
    chk({1'b0, sel_code_o}, 8'd0, "R8 high range default");
    lvl_sel_i = 1'b1; lvl_code_i = 7'h2a; cyc(1);
    chk({1'b0, sel_code_o}, 8'h2a, "R7 user code");
    lvl_code_i = 7'h7f; range_hi_i = 1'b0; cyc(1);
    chk({1'b0, sel_code_o}, 8'h7f, "R7 user code ignores range");
    lvl_sel_i = 1'b0; cyc(1);
    chk({1'b0, sel_code_o}, 8'd64, "R8 back to default");
  endtask

  initial begin
    t_reset();
    t_follow();
    t_rise_mask();
    t_fall_mask();
    t_disabled();
    t_no_tick();
    t_midchange();
    t_reopen();
    t_level();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1-scope run: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule